// File: doc/BRIEF.md
# Guarded Configuration Register Bank

This block is a byte-wide register bank that sits behind a serial slave front end. It serves a parallel register port with a 7-bit address, a write strobe and a read strobe. The 128-byte address space holds 25 writable configuration bytes, four read-only configuration bytes fixed by a parameter, four user-data bytes, a read-only release byte, and four error-memory bytes. Some bytes are also visible at mirror addresses.

Writes are checked against rules that depend on both the address and the data. In the mode register, bit 7 is the driver-enable flag:
- Writing that bit as 0 stores the whole byte.
- Writing it as 1 sets the flag and commits the operating mode held in bits 6:0, and leaves those bits unchanged.

The slave-control register accepts a write only if the written byte keeps its slave-enable bit at 1. The block drives a driver-enable output and the committed operating mode. The error memory is loaded as one 32-bit word on a capture strobe.

Top module: `guarded_cfg_bank`

## Requirements
- R1: After a synchronous reset every configuration and user-data byte reads 0x00, except register 0x17, which reads 0x08. `rdata`, `drv_enable` and `op_mode` are 0.
- R2: A write to 0x00–0x01, 0x03–0x16 or 0x18 stores the byte. A read strobe loads `rdata` with the addressed byte on the next clock edge. `rdata` holds its value while no read strobe is given.
- R3: Reads at 0x38 return register 0x18. Reads at 0x3B–0x3E return user bytes 0x1B–0x1E, which are themselves writable. Writes at the mirror addresses change nothing.
- R4: Address 0x1F reads the parameter `CHIP_REL` (default 0x05), and writes to it change nothing.
- R5: Addresses 0x20–0x23 read bytes 0..3 of the parameter `HI_CFG_INIT`, where byte i is bits 8i+7:8i (default 0xA3B2C1D0). Writes to them change nothing.
- R6: Addresses 0x19–0x1A, 0x24–0x37, 0x39–0x3A, 0x3F and 0x44–0x7F read 0x00, and writes to them change nothing.
- R7: A write to 0x02 with bit 7 = 0 stores all eight bits. The driver-enable flag becomes 0 and `op_mode` is unchanged.
- R8: A write to 0x02 with bit 7 = 1 sets bit 7 and keeps bits 6:0. From the next edge `op_mode` equals the bits 6:0 held before the write.
- R9: A write to 0x17 stores the byte only if its bit 3 is 1. Otherwise it is ignored. `drv_enable` is bit 7 of 0x02 AND bit 3 of 0x17.
- R10: `err_capture` loads `err_word` into the error memory. 0x40+i reads byte i (bits 8i+7:8i). Writes to 0x40–0x43 change nothing.
- R11: When a read and a write, or a read and an error capture, fall in the same cycle, `rdata` returns the contents held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 7 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| err_word | input | 32 | Error-memory load value |
| err_capture | input | 1 | Error-memory load strobe |
| rdata | output | 8 | Registered read data |
| drv_enable | output | 1 | Output-driver enable |
| op_mode | output | 7 | Committed operating mode |

## Verification
Two pairs of events can fall in the same cycle and race for the registered read path:
- a register update and a read of that same address;
- an error-memory capture and a read of the first error byte.

Both pairs are provoked by raising both strobes in one cycle and then reading again. The scoreboard expects the value held before that edge from the combined cycle, and the new value from the following read.

// File: rtl/gcb_pkg.sv
package gcb_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int IDX_W   = 5;
    localparam int CFG_N   = 25;
    localparam int USR_N   = 4;
    localparam int ERR_N   = 4;

    localparam int MODE_REG = 2;
    localparam int SLV_REG  = 23;
    localparam int SLV_BIT  = 3;
    localparam int DRV_BIT  = 7;
    localparam logic [DATA_W-1:0] SLV_RST = 8'h08;

    localparam logic [ADDR_W-1:0] A_CFG_LAST  = 7'h18;
    localparam logic [ADDR_W-1:0] A_USR_LO    = 7'h1B;
    localparam logic [ADDR_W-1:0] A_USR_HI    = 7'h1E;
    localparam logic [ADDR_W-1:0] A_ROM       = 7'h1F;
    localparam logic [ADDR_W-1:0] A_HICFG_LO  = 7'h20;
    localparam logic [ADDR_W-1:0] A_HICFG_HI  = 7'h23;
    localparam logic [ADDR_W-1:0] A_CFG_ALIAS = 7'h38;
    localparam logic [ADDR_W-1:0] A_USRM_LO   = 7'h3B;
    localparam logic [ADDR_W-1:0] A_USRM_HI   = 7'h3E;
    localparam logic [ADDR_W-1:0] A_ERR_LO    = 7'h40;
    localparam logic [ADDR_W-1:0] A_ERR_HI    = 7'h43;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CFG,
        RG_HICFG,
        RG_USR,
        RG_ROM,
        RG_ERR
    } region_e;

    typedef struct packed {
        region_e           kind;
        logic [IDX_W-1:0]  idx;
        logic              wr_ok;
    } slot_t;

    function automatic slot_t decode_addr(input logic [ADDR_W-1:0] a);
        slot_t s;
        s.kind  = RG_NONE;
        s.idx   = '0;
        s.wr_ok = 1'b0;
        if (a <= A_CFG_LAST) begin
            s.kind  = RG_CFG;
            s.idx   = IDX_W'(a);
            s.wr_ok = 1'b1;
        end else if (a >= A_USR_LO && a <= A_USR_HI) begin
            s.kind  = RG_USR;
            s.idx   = IDX_W'(a - A_USR_LO);
            s.wr_ok = 1'b1;
        end else if (a == A_ROM) begin
            s.kind  = RG_ROM;
        end else if (a >= A_HICFG_LO && a <= A_HICFG_HI) begin
            s.kind  = RG_HICFG;
            s.idx   = IDX_W'(a - A_HICFG_LO);
        end else if (a == A_CFG_ALIAS) begin
            s.kind  = RG_CFG;
            s.idx   = IDX_W'(A_CFG_LAST);
        end else if (a >= A_USRM_LO && a <= A_USRM_HI) begin
            s.kind  = RG_USR;
            s.idx   = IDX_W'(a - A_USRM_LO);
        end else if (a >= A_ERR_LO && a <= A_ERR_HI) begin
            s.kind  = RG_ERR;
            s.idx   = IDX_W'(a - A_ERR_LO);
        end
        return s;
    endfunction

    // Data-dependent acceptance of a configuration write.
    function automatic logic write_allowed(input int reg_i, input logic [DATA_W-1:0] d);
        if (reg_i == SLV_REG) return d[SLV_BIT];
        return 1'b1;
    endfunction

    // Value stored by an accepted configuration write.
    function automatic logic [DATA_W-1:0] guarded_value(input int reg_i,
                                                        input logic [DATA_W-1:0] old,
                                                        input logic [DATA_W-1:0] d);
        if (reg_i == MODE_REG && d[DRV_BIT]) return {1'b1, old[DATA_W-2:0]};
        return d;
    endfunction

endpackage

// File: rtl/gcb_decode.sv
module gcb_decode
    import gcb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output slot_t             slot
);
    always_comb slot = decode_addr(addr);
endmodule

// File: rtl/gcb_cfg_store.sv
module gcb_cfg_store
    import gcb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_cfg,
    input  logic                    wr_usr,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [DATA_W-1:0]       wdata,
    output logic [CFG_N*DATA_W-1:0] cfg_flat,
    output logic [USR_N*DATA_W-1:0] usr_flat,
    output logic [DATA_W-2:0]       mode_q
);
    logic [DATA_W-1:0] cfg_q [CFG_N];
    logic [DATA_W-1:0] usr_q [USR_N];

    for (genvar i = 0; i < CFG_N; i++) begin : g_cfg
        localparam logic [DATA_W-1:0] RST_V = (i == SLV_REG) ? SLV_RST : '0;
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[i] <= RST_V;
            else if (wr_cfg && wr_idx == IDX_W'(i) && write_allowed(i, wdata))
                cfg_q[i] <= guarded_value(i, cfg_q[i], wdata);
        end
        assign cfg_flat[i*DATA_W +: DATA_W] = cfg_q[i];
    end

    for (genvar j = 0; j < USR_N; j++) begin : g_usr
        always_ff @(posedge clk) begin
            if (rst)
                usr_q[j] <= '0;
            else if (wr_usr && wr_idx == IDX_W'(j))
                usr_q[j] <= wdata;
        end
        assign usr_flat[j*DATA_W +: DATA_W] = usr_q[j];
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (wr_cfg && wr_idx == IDX_W'(MODE_REG) && wdata[DRV_BIT])
            mode_q <= cfg_q[MODE_REG][DATA_W-2:0];
    end

    // R9
    slv_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cfg && wr_idx == IDX_W'(SLV_REG) && !wdata[SLV_BIT]) |=> $stable(cfg_q[SLV_REG]));

    // R8
    mode_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cfg && wr_idx == IDX_W'(MODE_REG) && wdata[DRV_BIT])
        |=> (mode_q == $past(cfg_q[MODE_REG][DATA_W-2:0])) && cfg_q[MODE_REG][DRV_BIT]
            && $stable(cfg_q[MODE_REG][DATA_W-2:0]));

    // R7
    mode_plain_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cfg && wr_idx == IDX_W'(MODE_REG) && !wdata[DRV_BIT])
        |=> $stable(mode_q) && (cfg_q[MODE_REG] == $past(wdata)));
endmodule

// File: rtl/gcb_err_capture.sv
module gcb_err_capture
    import gcb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    capture,
    input  logic [ERR_N*DATA_W-1:0] word_in,
    output logic [ERR_N*DATA_W-1:0] err_q
);
    always_ff @(posedge clk) begin
        if (rst)          err_q <= '0;
        else if (capture) err_q <= word_in;
    end

    // R10
    err_load_chk: assert property (@(posedge clk) disable iff (rst)
        capture |=> err_q == $past(word_in));

    // R10
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(err_q));
endmodule

// File: rtl/guarded_cfg_bank.sv
module guarded_cfg_bank
    import gcb_pkg::*;
#(
    parameter logic [7:0]  CHIP_REL    = 8'h05,
    parameter logic [31:0] HI_CFG_INIT = 32'hA3B2C1D0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [6:0]  addr,
    input  logic [7:0]  wdata,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [31:0] err_word,
    input  logic        err_capture,
    output logic [7:0]  rdata,
    output logic        drv_enable,
    output logic [6:0]  op_mode
);
    slot_t                    slot;
    logic                     wr_cfg, wr_usr;
    logic [CFG_N*DATA_W-1:0]  cfg_flat;
    logic [USR_N*DATA_W-1:0]  usr_flat;
    logic [ERR_N*DATA_W-1:0]  err_flat;
    logic [DATA_W-1:0]        rd_mux;

    gcb_decode u_dec (
        .addr (addr),
        .slot (slot)
    );

    assign wr_cfg = wr_en && slot.wr_ok && slot.kind == RG_CFG;
    assign wr_usr = wr_en && slot.wr_ok && slot.kind == RG_USR;

    gcb_cfg_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_cfg   (wr_cfg),
        .wr_usr   (wr_usr),
        .wr_idx   (slot.idx),
        .wdata    (wdata),
        .cfg_flat (cfg_flat),
        .usr_flat (usr_flat),
        .mode_q   (op_mode)
    );

    gcb_err_capture u_err (
        .clk     (clk),
        .rst     (rst),
        .capture (err_capture),
        .word_in (err_word),
        .err_q   (err_flat)
    );

    always_comb begin
        unique case (slot.kind)
            RG_CFG:   rd_mux = cfg_flat[slot.idx*DATA_W +: DATA_W];
            RG_USR:   rd_mux = usr_flat[slot.idx[1:0]*DATA_W +: DATA_W];
            RG_HICFG: rd_mux = HI_CFG_INIT[slot.idx[1:0]*DATA_W +: DATA_W];
            RG_ERR:   rd_mux = err_flat[slot.idx[1:0]*DATA_W +: DATA_W];
            RG_ROM:   rd_mux = CHIP_REL;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign drv_enable = cfg_flat[MODE_REG*DATA_W + DRV_BIT] & cfg_flat[SLV_REG*DATA_W + SLV_BIT];

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R4
    rom_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == A_ROM) |=> rdata == CHIP_REL);

    // R6
    hole_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && slot.kind == RG_NONE) |=> rdata == 8'h00);

    // R9
    slave_bit_kept_chk: assert property (@(posedge clk) disable iff (rst)
        $past(drv_enable) == 1'b0 || cfg_flat[MODE_REG*DATA_W + DRV_BIT] == drv_enable);
endmodule

// File: tb/guarded_cfg_bank_bench.sv
module guarded_cfg_bank_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] err_word = '0;
    logic        err_capture = 1'b0;
    logic [7:0]  rdata;
    logic        drv_enable;
    logic [6:0]  op_mode;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    logic rd_seen = 1'b0;

    typedef struct {
        logic [7:0] exp;
        logic [6:0] a;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    guarded_cfg_bank u_guarded_cfg_bank (
        .clk         (clk),
        .rst         (rst),
        .addr        (addr),
        .wdata       (wdata),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .err_word    (err_word),
        .err_capture (err_capture),
        .rdata       (rdata),
        .drv_enable  (drv_enable),
        .op_mode     (op_mode)
    );

    always @(posedge clk) rd_seen <= rd_en;

    // Monitor: compares each registered read against the scoreboard head.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL scoreboard empty: rdata=%h expected=none", rdata);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rdata, it.exp);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.a = a; it.tag = tag;
        sb_q.push_back(it);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_wr(input logic [6:0] a, input logic [7:0] d,
                         input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.a = a; it.tag = tag;
        sb_q.push_back(it);
        addr = a; wdata = d; rd_en = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1
        check("R1 rdata", rdata, 8'h00);
        check("R1 drv_enable", {7'b0, drv_enable}, 8'h00);
        check("R1 op_mode", {1'b0, op_mode}, 8'h00);
        rd(7'h05, 8'h00, "R1 cfg reset");
        rd(7'h17, 8'h08, "R1 slave reg reset");

        // R2
        wr(7'h00, 8'h11); wr(7'h10, 8'h5A); wr(7'h18, 8'hC3);
        rd(7'h00, 8'h11, "R2 cfg 0x00");
        rd(7'h10, 8'h5A, "R2 cfg 0x10");
        rd(7'h18, 8'hC3, "R2 cfg 0x18");
        repeat (3) @(negedge clk);
        check("R2 rdata hold", rdata, 8'hC3);

        // R3
        rd(7'h38, 8'hC3, "R3 alias 0x38");
        wr(7'h1B, 8'hAA); wr(7'h1E, 8'h55);
        rd(7'h3B, 8'hAA, "R3 mirror 0x3B");
        rd(7'h3E, 8'h55, "R3 mirror 0x3E");
        rd(7'h1B, 8'hAA, "R3 user 0x1B");
        wr(7'h3C, 8'h77); wr(7'h38, 8'h99);
        rd(7'h1C, 8'h00, "R3 mirror write ignored");
        rd(7'h18, 8'hC3, "R3 alias write ignored");

        // R4
        rd(7'h1F, 8'h05, "R4 release");
        wr(7'h1F, 8'hFF);
        rd(7'h1F, 8'h05, "R4 release write ignored");

        // R5
        rd(7'h20, 8'hD0, "R5 hicfg 0x20");
        rd(7'h23, 8'hA3, "R5 hicfg 0x23");
        wr(7'h21, 8'h00);
        rd(7'h21, 8'hC1, "R5 hicfg write ignored");

        // R6
        rd(7'h19, 8'h00, "R6 hole 0x19");
        rd(7'h30, 8'h00, "R6 hole 0x30");
        rd(7'h3F, 8'h00, "R6 hole 0x3F");
        rd(7'h7F, 8'h00, "R6 hole 0x7F");
        wr(7'h19, 8'hEE); wr(7'h44, 8'hEE);
        rd(7'h19, 8'h00, "R6 hole write 0x19");
        rd(7'h44, 8'h00, "R6 hole write 0x44");

        // R7
        wr(7'h02, 8'h2A);
        check("R7 drv off", {7'b0, drv_enable}, 8'h00);
        check("R7 mode kept", {1'b0, op_mode}, 8'h00);
        rd(7'h02, 8'h2A, "R7 plain store");

        // R8
        wr(7'h02, 8'h80);
        check("R8 mode commit", {1'b0, op_mode}, 8'h2A);
        check("R8 drv on", {7'b0, drv_enable}, 8'h01);
        rd(7'h02, 8'hAA, "R8 low bits kept");
        wr(7'h02, 8'h13);
        check("R7 drv off again", {7'b0, drv_enable}, 8'h00);
        check("R7 mode unchanged", {1'b0, op_mode}, 8'h2A);
        wr(7'h02, 8'hFF);
        check("R8 second commit", {1'b0, op_mode}, 8'h13);
        rd(7'h02, 8'h93, "R8 second keep");

        // R9
        wr(7'h17, 8'hF7);
        rd(7'h17, 8'h08, "R9 clear attempt ignored");
        check("R9 drv stays", {7'b0, drv_enable}, 8'h01);
        wr(7'h17, 8'hFF);
        rd(7'h17, 8'hFF, "R9 accepted write");
        wr(7'h17, 8'h00);
        rd(7'h17, 8'hFF, "R9 zero write ignored");

        // R10
        err_word = 32'hDEADBEEF; err_capture = 1'b1;
        @(negedge clk);
        err_capture = 1'b0; err_word = 32'h0;
        rd(7'h40, 8'hEF, "R10 err byte0");
        rd(7'h41, 8'hBE, "R10 err byte1");
        rd(7'h42, 8'hAD, "R10 err byte2");
        rd(7'h43, 8'hDE, "R10 err byte3");
        wr(7'h40, 8'h00);
        rd(7'h40, 8'hEF, "R10 err write ignored");

        // R11
        wr(7'h05, 8'h44);
        rd_wr(7'h05, 8'h99, 8'h44, "R11 read-during-write old");
        rd(7'h05, 8'h99, "R11 new value after");
        err_word = 32'h01234567; err_capture = 1'b1;
        sb_q.push_back('{exp: 8'hEF, a: 7'h40, tag: "R11 read-during-capture old"});
        addr = 7'h40; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; err_capture = 1'b0;
        rd(7'h40, 8'h67, "R11 captured after");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule